// File: doc/BRIEF.md
# Clocked Serial Receiver with FIFO

This block receives bytes from a clock-synchronous serial link. A serial clock and a serial data line arrive from outside the system clock domain. Both pass through multi-flop synchronizers. On each rising edge of the synchronized serial clock, one data bit is taken into a shift register, least significant bit first. When the eighth bit of a frame arrives, the assembled byte is offered to a 16-entry receive FIFO.

If the FIFO has room, the byte is stored. A data-ready flag rises once the FIFO occupancy reaches a selectable threshold. If the FIFO is full, the byte is dropped and an overrun flag is raised. While that flag stands, the receiver ignores the line completely.

Two interrupt outputs are formed from the flags and enable inputs. One is a data-ready interrupt. The other is an overrun (break) interrupt, which either of two enables can turn on. Software drains the FIFO through a read strobe. It clears the flags and empties the FIFO through dedicated strobes.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `ready_o`, `overrun_o`, `rx_irq_o` and `brk_irq_o` are 0 and `fifo_count_o` is 0.
- R2: Each frame is 8 bits taken on rising edges of the serial clock. The first bit received becomes bit 0 of the byte and the eighth becomes bit 7.
- R3: A completed frame is written to the FIFO when the FIFO is not full. Bytes come out in arrival order, the oldest is shown on `rd_data_o`, and a `rd_i` pulse removes it.
- R4: If a frame completes while the FIFO holds 16 bytes, the byte is discarded, `fifo_count_o` is unchanged and `overrun_o` becomes 1.
- R5: While `overrun_o` is 1, serial clock edges do not change the receiver. After `ovr_clr_i` the next received bit starts a new frame.
- R6: `ready_o` becomes 1 when a write brings the FIFO count to at least the threshold chosen by `trig_sel_i`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. Below the threshold it stays 0.
- R7: `ready_clr_i` sets `ready_o` to 0. Reading the FIFO does not clear it.
- R8: `rx_irq_o` is 1 exactly when `ready_o` and `rx_ie_i` are both 1.
- R9: `brk_irq_o` is 1 exactly when `overrun_o` is 1 and at least one of `rx_ie_i` and `err_ie_i` is 1.
- R10: While `rx_en_i` is 0, a partial frame is abandoned: the bit count and the shift register are reset. The FIFO contents are kept.
- R11: `fifo_rst_i` empties the FIFO, so `fifo_count_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_data_i | input | 1 | Serial data, asynchronous to clk |
| rx_en_i | input | 1 | Receive enable |
| rx_ie_i | input | 1 | Data-ready interrupt enable (also enables the break interrupt) |
| err_ie_i | input | 1 | Error interrupt enable for the break interrupt |
| trig_sel_i | input | 2 | Ready threshold select: 0→1, 1→4, 2→8, 3→14 |
| rd_i | input | 1 | One-cycle pulse that pops the oldest FIFO byte |
| ready_clr_i | input | 1 | Clears the data-ready flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| fifo_rst_i | input | 1 | Empties the FIFO |
| rd_data_o | output | 8 | Oldest byte in the FIFO |
| fifo_count_o | output | 5 | Number of bytes held |
| ready_o | output | 1 | Data-ready flag |
| overrun_o | output | 1 | Overrun flag |
| rx_irq_o | output | 1 | Data-ready interrupt request |
| brk_irq_o | output | 1 | Overrun (break) interrupt request |

## Verification
The assertions assume the serial clock is slow next to `clk`: each of its levels must last at least three system cycles, and the data must be settled before the rising edge. They also assume `rd_i` is not pulsed in the cycle a frame completes. The stimulus holds each serial clock level for six system cycles and changes data only while the serial clock is low. Reads and flag clears are issued only between frames, so the ready threshold and the overrun discard are always seen without a competing pop.

// File: rtl/sserx_pkg.sv
// Package sserx_pkg
// Holds the shared frame width and the encoding of the threshold selector.
// Assumes frames are a whole byte.
package sserx_pkg;
    localparam int FRAME_BITS = 8;

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_sel_e;
endpackage

// File: rtl/sserx_sync.sv
// Module sserx_sync
// A bank of multi-stage synchronizers, one per input bit. It brings
// asynchronous signals into the clk domain. It assumes each input level
// is held long enough to be seen by the first stage.
module sserx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: the first stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Purpose: each later stage re-times the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sserx_shifter.sv
// Module sserx_shifter
// Collects serial bits LSB first and flags the completion of a frame.
// It assumes bit_stb_i is a single-cycle strobe per serial clock rise.
// While hold_i is set, strobes are ignored. While en_i is clear, the
// partial frame is dropped.
module sserx_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            hold_i,
    input  logic            bit_stb_i,
    input  logic            bit_i,
    output logic            done_o,
    output logic [BITS-1:0] data_o
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0]   cnt_q;
    logic [BITS-1:0] sr_q;
    logic            take;

    assign take = en_i && bit_stb_i && !hold_i;

    // Purpose: shift in one bit per accepted strobe and count the bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (take) begin
            sr_q  <= {bit_i, sr_q[BITS-1:1]};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Purpose: report a finished frame together with its assembled byte.
    always_comb begin
        done_o = take && (cnt_q == LAST);
        data_o = {bit_i, sr_q[BITS-1:1]};
    end

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hold_i) |=> ($stable(cnt_q) && $stable(sr_q)));

    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && sr_q == '0));
endmodule

// File: rtl/sserx_fifo.sv
// Module sserx_fifo
// A first-word-fall-through FIFO with an occupancy count. A push when
// full and a pop when empty are ignored, and flush empties the FIFO.
// It assumes the caller checks full_o before pushing.
module sserx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     push_i,
    input  logic [WIDTH-1:0]         push_data_i,
    input  logic                     pop_i,
    output logic [WIDTH-1:0]         head_o,
    output logic                     full_o,
    output logic                     empty_o,
    output logic [$clog2(DEPTH):0]   count_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    // Purpose: qualify the requests against the occupancy.
    always_comb begin
        full_o  = (cnt_q == CNT_FULL);
        empty_o = (cnt_q == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
    end

    // Purpose: store the pushed byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= push_data_i;
    end

    // Purpose: advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr_q];
    assign count_o = cnt_q;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
endmodule

// File: rtl/sync_serial_rx.sv
// Module sync_serial_rx
// The top of the clocked serial receive path. It synchronizes the line,
// finds serial clock rises, assembles frames, and writes them to the FIFO
// or flags an overrun. It keeps the ready and overrun flags and forms the
// two interrupt requests. It assumes the serial clock is much slower than
// clk and that rd_i is not pulsed in the cycle a frame completes.
module sync_serial_rx #(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk_i,
    input  logic                        ser_data_i,
    input  logic                        rx_en_i,
    input  logic                        rx_ie_i,
    input  logic                        err_ie_i,
    input  logic [1:0]                  trig_sel_i,
    input  logic                        rd_i,
    input  logic                        ready_clr_i,
    input  logic                        ovr_clr_i,
    input  logic                        fifo_rst_i,
    output logic [7:0]                  rd_data_o,
    output logic [$clog2(FIFO_DEPTH):0] fifo_count_o,
    output logic                        ready_o,
    output logic                        overrun_o,
    output logic                        rx_irq_o,
    output logic                        brk_irq_o
);
    import sserx_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [1:0]    line_s;
    logic          sclk_s, sdat_s, sclk_prev_q;
    logic          bit_stb;
    logic          frame_done;
    frame_t        frame_data;
    logic          fifo_full, fifo_empty, fifo_push;
    logic [CW-1:0] trig_lvl;
    logic [CW-1:0] cnt_next;
    logic          ready_q, ovr_q;

    sserx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ser_data_i}),
        .sync_o  (line_s)
    );

    assign sclk_s = line_s[1];
    assign sdat_s = line_s[0];

    // Purpose: remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign bit_stb = sclk_s && !sclk_prev_q;

    sserx_shifter #(.BITS(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en_i),
        .hold_i    (ovr_q),
        .bit_stb_i (bit_stb),
        .bit_i     (sdat_s),
        .done_o    (frame_done),
        .data_o    (frame_data)
    );

    assign fifo_push = frame_done && !fifo_full;

    sserx_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (fifo_rst_i),
        .push_i      (fifo_push),
        .push_data_i (frame_data),
        .pop_i       (rd_i),
        .head_o      (rd_data_o),
        .full_o      (fifo_full),
        .empty_o     (fifo_empty),
        .count_o     (fifo_count_o)
    );

    // Purpose: decode the threshold selector into a FIFO count.
    always_comb begin
        case (trig_sel_e'(trig_sel_i))
            TRIG_ONE:      trig_lvl = CW'(1);
            TRIG_FOUR:     trig_lvl = CW'(4);
            TRIG_EIGHT:    trig_lvl = CW'(8);
            default:       trig_lvl = CW'(14);
        endcase
        cnt_next = fifo_count_o + 1'b1;
    end

    // Purpose: set ready when a write reaches the threshold, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ready_q <= 1'b0;
        else if (fifo_push && cnt_next >= trig_lvl) ready_q <= 1'b1;
        else if (ready_clr_i)                    ready_q <= 1'b0;
    end

    // Purpose: set overrun when a frame meets a full FIFO, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovr_q <= 1'b0;
        else if (frame_done && fifo_full) ovr_q <= 1'b1;
        else if (ovr_clr_i)              ovr_q <= 1'b0;
    end

    // Purpose: drive the flags and the interrupt requests.
    always_comb begin
        ready_o   = ready_q;
        overrun_o = ovr_q;
        rx_irq_o  = ready_q && rx_ie_i;
        brk_irq_o = ovr_q && (rx_ie_i || err_ie_i);
    end

    p_ovr_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && fifo_full) |=> overrun_o);

    p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && fifo_full && !rd_i && !fifo_rst_i) |=> $stable(fifo_count_o));

    p_ready_at_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && cnt_next >= trig_lvl) |=> ready_o);

    p_read_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !fifo_empty && !frame_done && !fifo_rst_i)
            |=> (fifo_count_o == $past(fifo_count_o) - 1'b1));
endmodule

// File: tb/sync_serial_rx_tb_top.sv
`timescale 1ns/1ps
module sync_serial_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0;
    logic       rx_en = 1'b0, rx_ie = 1'b0, err_ie = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rd = 1'b0, ready_clr = 1'b0, ovr_clr = 1'b0, fifo_rst = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fifo_count;
    logic       ready, overrun, rx_irq, brk_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .rx_en_i(rx_en), .rx_ie_i(rx_ie), .err_ie_i(err_ie), .trig_sel_i(trig_sel),
        .rd_i(rd), .ready_clr_i(ready_clr), .ovr_clr_i(ovr_clr), .fifo_rst_i(fifo_rst),
        .rd_data_o(rd_data), .fifo_count_o(fifo_count), .ready_o(ready),
        .overrun_o(overrun), .rx_irq_o(rx_irq), .brk_irq_o(brk_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = b[i];
            ser_clk  = 1'b0;
            repeat (6) @(negedge clk);
            ser_clk  = 1'b1;
            repeat (6) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
        @(negedge clk);
    endtask

    task automatic clean_start(input logic [1:0] t);
        trig_sel = t;
        pulse(fifo_rst);
        pulse(ready_clr);
        pulse(ovr_clr);
    endtask

    task automatic t_reset();
        chk("R1 ready", ready, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 count", fifo_count, 0);
        chk("R1 irqs", {rx_irq, brk_irq}, 0);
    endtask

    task automatic t_single();
        clean_start(2'd0);
        rx_ie = 1'b1;
        send_bits(8'hA5, 8);
        chk("R2 lsb first byte", rd_data, 8'hA5);
        chk("R3 count one", fifo_count, 1);
        chk("R6 ready at 1", ready, 1);
        chk("R8 rx_irq", rx_irq, 1);
        rx_ie = 1'b0;
        @(negedge clk);
        chk("R8 rx_irq masked", rx_irq, 0);
        pulse(rd);
        chk("R7 ready kept after read", ready, 1);
        pulse(ready_clr);
        chk("R7 ready cleared", ready, 0);
    endtask

    task automatic t_trig4();
        clean_start(2'd1);
        send_bits(8'h01, 8);
        send_bits(8'h80, 8);
        send_bits(8'h3C, 8);
        chk("R6 below threshold 4", ready, 0);
        send_bits(8'hE7, 8);
        chk("R6 threshold 4", ready, 1);
        chk("R3 order 0", rd_data, 8'h01); pulse(rd);
        chk("R3 order 1", rd_data, 8'h80); pulse(rd);
        chk("R3 order 2", rd_data, 8'h3C); pulse(rd);
        chk("R3 order 3", rd_data, 8'hE7); pulse(rd);
        chk("R3 drained", fifo_count, 0);
    endtask

    task automatic t_overrun();
        clean_start(2'd3);
        rx_ie = 1'b0; err_ie = 1'b1;
        for (int i = 0; i < 13; i++) send_bits(8'h10 + 8'(i), 8);
        chk("R6 below threshold 14", ready, 0);
        send_bits(8'h1D, 8);
        chk("R6 threshold 14", ready, 1);
        send_bits(8'h1E, 8);
        send_bits(8'h1F, 8);
        chk("R3 full count", fifo_count, 16);
        chk("R4 no overrun yet", overrun, 0);
        send_bits(8'hEE, 8);
        chk("R4 overrun set", overrun, 1);
        chk("R4 count unchanged", fifo_count, 16);
        chk("R9 brk by err enable", brk_irq, 1);
        err_ie = 1'b0;
        @(negedge clk);
        chk("R9 brk masked", brk_irq, 0);
        rx_ie = 1'b1;
        @(negedge clk);
        chk("R9 brk by rx enable", brk_irq, 1);
        rx_ie = 1'b0;
        send_bits(8'h77, 5);
        chk("R5 held count", fifo_count, 16);
        pulse(ovr_clr);
        chk("R5 overrun cleared", overrun, 0);
        pulse(rd);
        send_bits(8'h3C, 8);
        chk("R5 resumed count", fifo_count, 16);
        for (int i = 1; i < 16; i++) begin
            chk("R4 kept entries", rd_data, 8'h10 + 8'(i));
            pulse(rd);
        end
        chk("R5 fresh frame", rd_data, 8'h3C);
        pulse(rd);
    endtask

    task automatic t_disable();
        clean_start(2'd0);
        send_bits(8'h5A, 8);
        send_bits(8'hFF, 3);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 fifo kept", fifo_count, 1);
        rx_en = 1'b1;
        @(negedge clk);
        send_bits(8'hC3, 8);
        chk("R10 count", fifo_count, 2);
        chk("R10 old byte", rd_data, 8'h5A);
        pulse(rd);
        chk("R10 clean frame", rd_data, 8'hC3);
    endtask

    task automatic t_flush();
        send_bits(8'h44, 8);
        chk("R11 before flush", fifo_count, 2);
        pulse(fifo_rst);
        chk("R11 flushed", fifo_count, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        t_single();
        t_trig4();
        t_overrun();
        t_disable();
        t_flush();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule